// File: doc/BRIEF.md
# Narrow-to-Wide Memory Port Width Up-Converter

This block sits between a master that issues narrow memory commands and a memory port whose data word is several narrow words wide (four by default). Each narrow command carries an address, a write flag, write data and an end-of-burst hint. Consecutive narrow commands that fall in the same wide word, keep the same direction and arrive in rising lane order on back-to-back cycles are merged into a single wide command. A per-lane select mask records which narrow lanes of the wide word were touched.

For writes, the narrow words are placed in their lanes of one wide word, and byte enables are raised only for the touched lanes. For reads, the select mask of each issued wide read is queued. When the wide read data returns, one narrow response per touched lane is produced, in the order the narrow commands were given. Any of these ends the pending group: an idle cycle, a direction change, a different wide address, a lane that does not follow the previous one, or the end-of-burst hint.

Top module: `mem_port_upsizer`

## Requirements
- R1: Narrow commands to the four lanes of one wide word (narrow address bits [1:0] = 0,1,2,3), same direction, on four consecutive cycles give exactly one wide command, whose address is the narrow address shifted right by two.
- R2: A cycle with no accepted narrow command closes the pending group. Writes 0,1, an idle cycle, then 2,3 give two wide commands.
- R3: A narrow command whose write flag differs from the pending group issues the pending group and opens a new group with itself.
- R4: A narrow command whose wide address (address >> 2) differs from the pending group closes the group. Writes 1,2,3,4 give wide address 0 with lanes 1..3, then wide address 1 with lane 0.
- R5: A narrow command with `up_last` high is the final member of its group. The next command, even on the following cycle, starts a new wide command.
- R6: A narrow command whose lane is not above the previous lane of the pending group starts a new group, so responses within a group follow command order.
- R7: On a wide write, lane k (bits 16k+15..16k) carries the narrow data written to lane k, and the byte enables for lane k (bits 2k+1..2k) are both set exactly when lane k was touched. A wide read has all byte enables clear.
- R8: For each wide read, exactly one narrow response is produced per touched lane, carrying that lane of the returned wide word, in command order.
- R9: While `dn_cmd_valid` is high and `dn_cmd_ready` is low, the wide command and all its fields stay unchanged.
- R10: After reset `dn_cmd_valid` and `up_rd_valid` are low and `up_cmd_ready` is high. No more than four wide reads are ever outstanding.
- R11: A narrow command that joins the pending group is accepted in the cycle it is presented, even while the wide side is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_cmd_valid | input | 1 | Narrow command present |
| up_cmd_ready | output | 1 | Narrow command accepted this cycle |
| up_cmd_we | input | 1 | 1 = write, 0 = read |
| up_cmd_addr | input | NAW (8) | Narrow word address |
| up_cmd_last | input | 1 | End-of-burst hint, closes the group |
| up_wdata | input | NDW (16) | Narrow write data, sent with the command |
| up_rd_valid | output | 1 | Narrow read response present |
| up_rd_data | output | NDW (16) | Narrow read response data |
| dn_cmd_valid | output | 1 | Wide command present |
| dn_cmd_ready | input | 1 | Wide command taken |
| dn_cmd_we | output | 1 | Wide command direction |
| dn_cmd_addr | output | NAW-2 (6) | Wide word address |
| dn_wdata | output | NDW*4 (64) | Wide write data |
| dn_wbe | output | NDW*4/8 (8) | Wide write byte enables |
| dn_rd_valid | input | 1 | Wide read data present |
| dn_rd_data | input | NDW*4 (64) | Wide read data |

## Verification
The group logic can issue the pending wide command in the same cycle that it accepts a narrow command which starts a new group. This happens on a direction change, a wide-address change, a lane that does not follow, or a command right after an end-of-burst hint. The bench provokes it by presenting the second command on the cycle directly after the first group's last member, while the wide side's ready signal stalls every third cycle. It judges the result by the exact list of wide commands (address, direction, byte enables) and by the narrow read data read back. A second overlap is a wide read return arriving while earlier reads are still being split into narrow responses. A run of single-lane reads against a long memory latency forces this and fills the mask queue. The bench checks the response order and the peak number of outstanding reads.

// File: rtl/upc_pkg.sv
// Package: shared defaults and helpers for the memory port up-converter.
// Assumes lane masks no wider than 32 bits.
package upc_pkg;

    parameter int UPC_NAW_DEF   = 8;
    parameter int UPC_NDW_DEF   = 16;
    parameter int UPC_RATIO_DEF = 4;
    parameter int UPC_DEPTH_DEF = 4;

    // Index of the lowest set bit of a lane mask (0 when the mask is empty).
    function automatic int unsigned upc_first_one(input logic [31:0] mask);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (mask[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/upc_fifo.sv
// Module: small synchronous FIFO used for read lane masks and wide read data.
// Assumes the producer never pushes when full and the consumer never pops
// when empty; the output shows the head entry while not empty.
module upc_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = store[rd_ptr];

    // Pointer step with wrap at DEPTH.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Write port: store the pushed entry.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/upc_gather.sv
// Module: narrow command gatherer. Keeps one pending group (direction, wide
// address, lane mask, packed write data, last lane) and moves it into the
// wide command register when the group ends. A group ends on an idle cycle,
// a direction or wide-address change, a non-rising lane, the last hint, or
// when its top lane is filled.
// Assumes read groups may leave only while the mask queue has room.
module upc_gather #(
    parameter int NAW   = 8,
    parameter int NDW   = 16,
    parameter int RATIO = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic                           in_we,
    input  logic [NAW-1:0]                 in_addr,
    input  logic                           in_last,
    input  logic [NDW-1:0]                 in_wdata,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic                           out_we,
    output logic [NAW-$clog2(RATIO)-1:0]   out_addr,
    output logic [NDW*RATIO-1:0]           out_data,
    output logic [NDW*RATIO/8-1:0]         out_be,
    input  logic                           mask_full,
    output logic                           mask_push,
    output logic [RATIO-1:0]               mask_din
);
    localparam int LW  = $clog2(RATIO);
    localparam int WAW = NAW - LW;
    localparam int WDW = NDW * RATIO;
    localparam int NBE = NDW / 8;
    localparam int WBE = WDW / 8;

    logic             pend_valid;
    logic             pend_closed;
    logic             pend_we;
    logic [WAW-1:0]   pend_waddr;
    logic [LW-1:0]    pend_lane;
    logic [RATIO-1:0] pend_sel;
    logic [WDW-1:0]   pend_data;
    logic [WBE-1:0]   pend_be;

    logic [LW-1:0]    in_lane;
    logic [WAW-1:0]   in_waddr;
    logic [RATIO-1:0] in_lane_bit;
    logic             joins;
    logic             slot_free;
    logic             can_issue;
    logic             accept;
    logic             accept_join;
    logic             issue;
    logic [WDW-1:0]   next_data;

    assign in_lane     = in_addr[LW-1:0];
    assign in_waddr    = in_addr[NAW-1:LW];
    assign in_lane_bit = RATIO'(1) << in_lane;

    // A command joins when the group is open and it continues the same word upward.
    assign joins = pend_valid && !pend_closed && (in_we == pend_we)
                 && (in_waddr == pend_waddr) && (in_lane > pend_lane);

    assign slot_free   = !out_valid || out_ready;
    assign can_issue   = slot_free && (pend_we || !mask_full);
    assign in_ready    = !pend_valid || joins || can_issue;
    assign accept      = in_valid && in_ready;
    assign accept_join = accept && joins;
    assign issue       = pend_valid && !accept_join && can_issue;

    assign mask_push = issue && !pend_we;
    assign mask_din  = pend_sel;

    // Pack incoming write data into its lane; keep earlier lanes when joining.
    always_comb begin
        next_data = '0;
        for (int k = 0; k < RATIO; k++) begin
            if (in_we && (in_lane == LW'(k)))
                next_data[k*NDW +: NDW] = in_wdata;
            else if (accept_join)
                next_data[k*NDW +: NDW] = pend_data[k*NDW +: NDW];
        end
    end

    // Expand the lane mask into byte enables for write groups.
    genvar gk;
    generate
        for (gk = 0; gk < RATIO; gk++) begin : g_be
            assign pend_be[gk*NBE +: NBE] = {NBE{pend_sel[gk] && pend_we}};
        end
    endgenerate

    // Pending group register: open, extend, release or close the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid  <= 1'b0;
            pend_closed <= 1'b0;
            pend_we     <= 1'b0;
            pend_waddr  <= '0;
            pend_lane   <= '0;
            pend_sel    <= '0;
            pend_data   <= '0;
        end else if (accept) begin
            pend_valid  <= 1'b1;
            pend_we     <= in_we;
            pend_waddr  <= in_waddr;
            pend_lane   <= in_lane;
            pend_data   <= next_data;
            pend_sel    <= accept_join ? (pend_sel | in_lane_bit) : in_lane_bit;
            pend_closed <= in_last || (in_lane == LW'(RATIO - 1));
        end else if (issue) begin
            pend_valid  <= 1'b0;
            pend_closed <= 1'b0;
        end else if (pend_valid) begin
            pend_closed <= 1'b1;
        end
    end

    // Wide command register: load on issue, hold until the far side takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
            out_be    <= '0;
        end else if (issue) begin
            out_valid <= 1'b1;
            out_we    <= pend_we;
            out_addr  <= pend_waddr;
            out_data  <= pend_we ? pend_data : '0;
            out_be    <= pend_be;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/upc_rd_split.sv
// Module: read response splitter. Takes one wide read word with its lane mask
// and emits one narrow word per set lane, lowest lane first, one per cycle.
// Assumes the queued mask and data heads belong to the same wide read.
module upc_rd_split #(
    parameter int NDW   = 16,
    parameter int RATIO = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RATIO-1:0]       mask_head,
    input  logic                   mask_empty,
    input  logic [NDW*RATIO-1:0]   data_head,
    input  logic                   data_empty,
    output logic                   pop,
    output logic                   rsp_valid,
    output logic [NDW-1:0]         rsp_data
);
    import upc_pkg::*;

    localparam int LW  = $clog2(RATIO);
    localparam int WDW = NDW * RATIO;

    logic             busy;
    logic [RATIO-1:0] lanes_left;
    logic [WDW-1:0]   word;
    logic [LW-1:0]    cur_lane;
    logic [RATIO-1:0] lanes_after;

    assign pop         = !busy && !mask_empty && !data_empty;
    assign cur_lane    = LW'(upc_first_one(32'(lanes_left)));
    assign lanes_after = lanes_left & ~(RATIO'(1) << cur_lane);
    assign rsp_valid   = busy;
    assign rsp_data    = word[cur_lane*NDW +: NDW];

    // Load a returned word, then step through its selected lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            lanes_left <= '0;
            word       <= '0;
        end else if (pop) begin
            busy       <= 1'b1;
            lanes_left <= mask_head;
            word       <= data_head;
        end else if (busy) begin
            lanes_left <= lanes_after;
            busy       <= (lanes_after != '0);
        end
    end

endmodule

// File: rtl/mem_port_upsizer.sv
// Module: top of the narrow-to-wide memory port up-converter. Joins the
// gatherer, the read lane-mask queue, the returned-word queue and the
// response splitter.
// Assumes the wide side returns read data in command order, one word per read.
module mem_port_upsizer #(
    parameter int NAW      = upc_pkg::UPC_NAW_DEF,
    parameter int NDW      = upc_pkg::UPC_NDW_DEF,
    parameter int RATIO    = upc_pkg::UPC_RATIO_DEF,
    parameter int RD_DEPTH = upc_pkg::UPC_DEPTH_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          up_cmd_valid,
    output logic                          up_cmd_ready,
    input  logic                          up_cmd_we,
    input  logic [NAW-1:0]                up_cmd_addr,
    input  logic                          up_cmd_last,
    input  logic [NDW-1:0]                up_wdata,
    output logic                          up_rd_valid,
    output logic [NDW-1:0]                up_rd_data,
    output logic                          dn_cmd_valid,
    input  logic                          dn_cmd_ready,
    output logic                          dn_cmd_we,
    output logic [NAW-$clog2(RATIO)-1:0]  dn_cmd_addr,
    output logic [NDW*RATIO-1:0]          dn_wdata,
    output logic [NDW*RATIO/8-1:0]        dn_wbe,
    input  logic                          dn_rd_valid,
    input  logic [NDW*RATIO-1:0]          dn_rd_data
);
    localparam int WDW = NDW * RATIO;

    logic             mask_push;
    logic [RATIO-1:0] mask_din;
    logic [RATIO-1:0] mask_head;
    logic             mask_empty;
    logic             mask_full;
    logic [WDW-1:0]   data_head;
    logic             data_empty;
    logic             data_full;
    logic             split_pop;

    upc_gather #(.NAW(NAW), .NDW(NDW), .RATIO(RATIO)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (up_cmd_valid),
        .in_ready  (up_cmd_ready),
        .in_we     (up_cmd_we),
        .in_addr   (up_cmd_addr),
        .in_last   (up_cmd_last),
        .in_wdata  (up_wdata),
        .out_valid (dn_cmd_valid),
        .out_ready (dn_cmd_ready),
        .out_we    (dn_cmd_we),
        .out_addr  (dn_cmd_addr),
        .out_data  (dn_wdata),
        .out_be    (dn_wbe),
        .mask_full (mask_full),
        .mask_push (mask_push),
        .mask_din  (mask_din)
    );

    upc_fifo #(.W(RATIO), .DEPTH(RD_DEPTH)) u_mask_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mask_push),
        .din   (mask_din),
        .pop   (split_pop),
        .dout  (mask_head),
        .empty (mask_empty),
        .full  (mask_full)
    );

    upc_fifo #(.W(WDW), .DEPTH(RD_DEPTH)) u_data_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dn_rd_valid),
        .din   (dn_rd_data),
        .pop   (split_pop),
        .dout  (data_head),
        .empty (data_empty),
        .full  (data_full)
    );

    upc_rd_split #(.NDW(NDW), .RATIO(RATIO)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_head  (mask_head),
        .mask_empty (mask_empty),
        .data_head  (data_head),
        .data_empty (data_empty),
        .pop        (split_pop),
        .rsp_valid  (up_rd_valid),
        .rsp_data   (up_rd_data)
    );

endmodule

// File: rtl/upc_checker.sv
// Module: assertion checker for the up-converter, bound to the top module.
// Assumes it sees the top-level ports only.
module upc_checker #(
    parameter int NAW      = 8,
    parameter int NDW      = 16,
    parameter int RATIO    = 4,
    parameter int RD_DEPTH = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          up_cmd_valid,
    input logic                          up_cmd_ready,
    input logic                          up_cmd_we,
    input logic                          up_rd_valid,
    input logic                          dn_cmd_valid,
    input logic                          dn_cmd_ready,
    input logic                          dn_cmd_we,
    input logic [NAW-$clog2(RATIO)-1:0]  dn_cmd_addr,
    input logic [NDW*RATIO-1:0]          dn_wdata,
    input logic [NDW*RATIO/8-1:0]        dn_wbe,
    input logic                          dn_rd_valid
);
    localparam int NBE = NDW / 8;

    int unsigned rd_outstanding;
    int unsigned narrow_reads;
    int unsigned narrow_rsps;

    // Track wide reads in flight and narrow read commands versus responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_outstanding <= 0;
            narrow_reads   <= 0;
            narrow_rsps    <= 0;
        end else begin
            rd_outstanding <= rd_outstanding
                            + ((dn_cmd_valid && dn_cmd_ready && !dn_cmd_we) ? 1 : 0)
                            - (dn_rd_valid ? 1 : 0);
            narrow_reads   <= narrow_reads
                            + ((up_cmd_valid && up_cmd_ready && !up_cmd_we) ? 1 : 0);
            narrow_rsps    <= narrow_rsps + (up_rd_valid ? 1 : 0);
        end
    end

    // R9: a stalled wide command holds every field.
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_cmd_valid && !dn_cmd_ready) |=> (dn_cmd_valid && $stable(dn_cmd_we)
            && $stable(dn_cmd_addr) && $stable(dn_wdata) && $stable(dn_wbe)));

    // R7: a wide read carries no byte enables.
    a_r7_read_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_cmd_valid && !dn_cmd_we) |-> (dn_wbe == '0));

    // R7: byte enables of one lane are all set or all clear.
    genvar gk;
    generate
        for (gk = 0; gk < RATIO; gk++) begin : g_lane
            a_r7_lane_whole: assert property (@(posedge clk) disable iff (!rst_n)
                dn_cmd_valid |-> ((dn_wbe[gk*NBE +: NBE] == '0)
                                  || (&dn_wbe[gk*NBE +: NBE])));
        end
    endgenerate

    // R10: wide reads in flight never exceed the mask queue depth.
    a_r10_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_outstanding <= RD_DEPTH);

    // R8: no narrow response without a narrow read still owed one.
    a_r8_rsp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        up_rd_valid |-> (narrow_rsps < narrow_reads));

endmodule

bind mem_port_upsizer upc_checker #(
    .NAW(NAW), .NDW(NDW), .RATIO(RATIO), .RD_DEPTH(RD_DEPTH)
) i_upc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_cmd_valid (up_cmd_valid),
    .up_cmd_ready (up_cmd_ready),
    .up_cmd_we    (up_cmd_we),
    .up_rd_valid  (up_rd_valid),
    .dn_cmd_valid (dn_cmd_valid),
    .dn_cmd_ready (dn_cmd_ready),
    .dn_cmd_we    (dn_cmd_we),
    .dn_cmd_addr  (dn_cmd_addr),
    .dn_wdata     (dn_wdata),
    .dn_wbe       (dn_wbe),
    .dn_rd_valid  (dn_rd_valid)
);

// File: tb/test_mem_port_upsizer.sv
// Bench: drives narrow command scripts and models the wide memory with a
// fixed read latency and a wide ready signal that stalls every third cycle.
module test_mem_port_upsizer;

    localparam int LAT = 12;

    logic        clk;
    logic        rst_n;
    logic        up_cmd_valid;
    logic        up_cmd_ready;
    logic        up_cmd_we;
    logic [7:0]  up_cmd_addr;
    logic        up_cmd_last;
    logic [15:0] up_wdata;
    logic        up_rd_valid;
    logic [15:0] up_rd_data;
    logic        dn_cmd_valid;
    logic        dn_cmd_ready;
    logic        dn_cmd_we;
    logic [5:0]  dn_cmd_addr;
    logic [63:0] dn_wdata;
    logic [7:0]  dn_wbe;
    logic        dn_rd_valid;
    logic [63:0] dn_rd_data;

    mem_port_upsizer i_mem_port_upsizer (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_cmd_valid (up_cmd_valid),
        .up_cmd_ready (up_cmd_ready),
        .up_cmd_we    (up_cmd_we),
        .up_cmd_addr  (up_cmd_addr),
        .up_cmd_last  (up_cmd_last),
        .up_wdata     (up_wdata),
        .up_rd_valid  (up_rd_valid),
        .up_rd_data   (up_rd_data),
        .dn_cmd_valid (dn_cmd_valid),
        .dn_cmd_ready (dn_cmd_ready),
        .dn_cmd_we    (dn_cmd_we),
        .dn_cmd_addr  (dn_cmd_addr),
        .dn_wdata     (dn_wdata),
        .dn_wbe       (dn_wbe),
        .dn_rd_valid  (dn_rd_valid),
        .dn_rd_data   (dn_rd_data)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [63:0] memw   [64];
    logic [15:0] shadow [256];

    logic        rec_we   [64];
    logic [5:0]  rec_addr [64];
    logic [7:0]  rec_be   [64];
    logic [63:0] rec_data [64];
    int          rec_n;
    logic [15:0] rsp      [64];
    int          rsp_n;

    logic [63:0] rq_word [64];
    int          rq_due  [64];
    int          rq_h = 0;
    int          rq_t = 0;
    int          out_cnt = 0;
    int          out_max = 0;

    logic        taken;
    logic        hold;
    logic        h_we;
    logic [5:0]  h_addr;
    logic [63:0] h_data;
    logic [7:0]  h_be;
    int          hold_bad = 0;
    int          hold_seen = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] be_of(input logic [3:0] sel);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            b[2*k]   = sel[k];
            b[2*k+1] = sel[k];
        end
        return b;
    endfunction

    // One bench cycle: drive the wide side, sample just after, step to next negedge.
    task automatic cycle();
        dn_cmd_ready = (cyc % 3) != 2;
        if (rq_h != rq_t && rq_due[rq_h % 64] <= cyc) begin
            dn_rd_valid = 1'b1;
            dn_rd_data  = rq_word[rq_h % 64];
            rq_h++;
            out_cnt--;
        end else begin
            dn_rd_valid = 1'b0;
        end
        #1;
        taken = up_cmd_valid && up_cmd_ready;
        if (hold) begin
            hold_seen++;
            if (!(dn_cmd_valid && dn_cmd_we == h_we && dn_cmd_addr == h_addr
                  && dn_wdata == h_data && dn_wbe == h_be)) hold_bad++;
        end
        hold = dn_cmd_valid && !dn_cmd_ready;
        h_we = dn_cmd_we; h_addr = dn_cmd_addr; h_data = dn_wdata; h_be = dn_wbe;
        if (dn_cmd_valid && dn_cmd_ready) begin
            rec_we[rec_n % 64]   = dn_cmd_we;
            rec_addr[rec_n % 64] = dn_cmd_addr;
            rec_be[rec_n % 64]   = dn_wbe;
            rec_data[rec_n % 64] = dn_wdata;
            rec_n++;
            if (dn_cmd_we) begin
                for (int b = 0; b < 8; b++)
                    if (dn_wbe[b]) memw[dn_cmd_addr][8*b +: 8] = dn_wdata[8*b +: 8];
            end else begin
                rq_word[rq_t % 64] = memw[dn_cmd_addr];
                rq_due[rq_t % 64]  = cyc + LAT;
                rq_t++;
                out_cnt++;
                if (out_cnt > out_max) out_max = out_cnt;
            end
        end
        if (up_rd_valid) begin
            rsp[rsp_n % 64] = up_rd_data;
            rsp_n++;
        end
        cyc++;
        @(negedge clk);
    endtask

    // Present one narrow command until taken; returns cycles spent.
    task automatic send(input logic we, input logic [7:0] addr, input logic [15:0] d,
                        input logic last, output int spent);
        up_cmd_valid = 1'b1;
        up_cmd_we    = we;
        up_cmd_addr  = addr;
        up_wdata     = d;
        up_cmd_last  = last;
        spent = 0;
        do begin
            cycle();
            spent++;
        end while (!taken);
        if (we) shadow[addr] = d;
    endtask

    task automatic idle(input int n);
        up_cmd_valid = 1'b0;
        up_cmd_last  = 1'b0;
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic start_phase();
        idle(40);
        rec_n = 0;
        rsp_n = 0;
    endtask

    task automatic chk_cmd(input int i, input logic we, input logic [5:0] a,
                           input logic [7:0] be, input string tag);
        chk(rec_we[i] == we, tag, 64'(rec_we[i]), 64'(we));
        chk(rec_addr[i] == a, tag, 64'(rec_addr[i]), 64'(a));
        if (we) chk(rec_be[i] == be, tag, 64'(rec_be[i]), 64'(be));
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sp;
        int tot;
        for (int a = 0; a < 256; a++) shadow[a] = 16'hC000 + 16'(a);
        for (int w = 0; w < 64; w++)
            for (int k = 0; k < 4; k++) memw[w][16*k +: 16] = 16'hC000 + 16'(4*w + k);
        rst_n = 1'b0; up_cmd_valid = 1'b0; up_cmd_we = 1'b0; up_cmd_addr = '0;
        up_cmd_last = 1'b0; up_wdata = '0; dn_cmd_ready = 1'b0;
        dn_rd_valid = 1'b0; dn_rd_data = '0; hold = 1'b0; rec_n = 0; rsp_n = 0;
        repeat (4) @(negedge clk);
        // R10: idle outputs during reset.
        chk(!dn_cmd_valid, "R10 reset dn_cmd_valid", 64'(dn_cmd_valid), 0);
        chk(!up_rd_valid, "R10 reset up_rd_valid", 64'(up_rd_valid), 0);
        chk(up_cmd_ready, "R10 reset up_cmd_ready", 64'(up_cmd_ready), 1);
        rst_n = 1'b1;

        // R1 and R11: aligned full word, each command taken at once.
        start_phase();
        tot = 0;
        for (int k = 0; k < 4; k++) begin
            send(1'b1, 8'(k), 16'h1100 + 16'(k), 1'b0, sp);
            tot += sp;
        end
        idle(20);
        chk(rec_n == 1, "R1 one wide write", 64'(rec_n), 1);
        chk_cmd(0, 1'b1, 6'd0, 8'hFF, "R1 full word");
        chk(rec_data[0] == 64'h1103_1102_1101_1100, "R7 packed data",
            rec_data[0], 64'h1103_1102_1101_1100);
        chk(tot == 4, "R11 accepted same cycle", 64'(tot), 4);

        // R2: idle gap splits the word.
        start_phase();
        send(1'b1, 8'd8, 16'h2200, 1'b0, sp);
        send(1'b1, 8'd9, 16'h2201, 1'b0, sp);
        idle(1);
        send(1'b1, 8'd10, 16'h2202, 1'b0, sp);
        send(1'b1, 8'd11, 16'h2203, 1'b0, sp);
        idle(20);
        chk(rec_n == 2, "R2 gap count", 64'(rec_n), 2);
        chk_cmd(0, 1'b1, 6'd2, be_of(4'b0011), "R2 first");
        chk_cmd(1, 1'b1, 6'd2, be_of(4'b1100), "R2 second");

        // R3: direction change, read half checked by data.
        start_phase();
        send(1'b1, 8'd12, 16'h3300, 1'b0, sp);
        send(1'b1, 8'd13, 16'h3301, 1'b0, sp);
        send(1'b0, 8'd14, 16'h0, 1'b0, sp);
        send(1'b0, 8'd15, 16'h0, 1'b0, sp);
        idle(40);
        chk(rec_n == 2, "R3 direction count", 64'(rec_n), 2);
        chk_cmd(0, 1'b1, 6'd3, be_of(4'b0011), "R3 write");
        chk_cmd(1, 1'b0, 6'd3, 8'h00, "R3 read");
        chk(rsp_n == 2, "R3 read rsps", 64'(rsp_n), 2);
        chk(rsp[0] == shadow[14], "R3 rsp0", 64'(rsp[0]), 64'(shadow[14]));
        chk(rsp[1] == shadow[15], "R3 rsp1", 64'(rsp[1]), 64'(shadow[15]));

        // R4: wide-address crossing 1,2,3,4.
        start_phase();
        for (int k = 1; k <= 4; k++) send(1'b1, 8'(16 + k), 16'h4400 + 16'(k), 1'b0, sp);
        idle(20);
        chk(rec_n == 2, "R4 crossing count", 64'(rec_n), 2);
        chk_cmd(0, 1'b1, 6'd4, be_of(4'b1110), "R4 first");
        chk_cmd(1, 1'b1, 6'd5, be_of(4'b0001), "R4 second");

        // R5: last hint splits otherwise mergeable commands.
        start_phase();
        send(1'b1, 8'd24, 16'h5500, 1'b1, sp);
        send(1'b1, 8'd25, 16'h5501, 1'b0, sp);
        idle(20);
        chk(rec_n == 2, "R5 last count", 64'(rec_n), 2);
        chk_cmd(0, 1'b1, 6'd6, be_of(4'b0001), "R5 first");
        chk_cmd(1, 1'b1, 6'd6, be_of(4'b0010), "R5 second");

        // R6: falling lane order starts a new group; reads return in command order.
        start_phase();
        send(1'b0, 8'd30, 16'h0, 1'b0, sp);
        send(1'b0, 8'd29, 16'h0, 1'b0, sp);
        idle(40);
        chk(rec_n == 2, "R6 order count", 64'(rec_n), 2);
        chk(rsp_n == 2, "R6 rsp count", 64'(rsp_n), 2);
        chk(rsp[0] == shadow[30], "R6 rsp0", 64'(rsp[0]), 64'(shadow[30]));
        chk(rsp[1] == shadow[29], "R6 rsp1", 64'(rsp[1]), 64'(shadow[29]));

        // R7 and R8 sweep: every start lane and length, write then read back.
        for (int s = 0; s < 4; s++) begin
            for (int len = 1; len <= 4 - s; len++) begin
                logic [5:0] wa;
                logic [3:0] sel;
                wa  = 6'(8 + 4*s + len);
                sel = 4'(((1 << len) - 1) << s);
                start_phase();
                for (int k = s; k < s + len; k++)
                    send(1'b1, {wa, 2'(k)}, 16'h7000 + 16'(wa) * 16'd16 + 16'(k),
                         k == s + len - 1, sp);
                for (int k = s; k < s + len; k++)
                    send(1'b0, {wa, 2'(k)}, 16'h0, k == s + len - 1, sp);
                idle(40);
                chk(rec_n == 2, "R7 sweep count", 64'(rec_n), 2);
                chk_cmd(0, 1'b1, wa, be_of(sel), "R7 sweep write");
                chk_cmd(1, 1'b0, wa, 8'h00, "R8 sweep read");
                chk(rsp_n == len, "R8 sweep rsp count", 64'(rsp_n), 64'(len));
                for (int k = 0; k < len; k++)
                    chk(rsp[k] == shadow[{wa, 2'(s + k)}], "R8 sweep data",
                        64'(rsp[k]), 64'(shadow[{wa, 2'(s + k)}]));
            end
        end

        // R10: many single-lane reads against a long latency.
        start_phase();
        out_max = 0;
        for (int i = 0; i < 6; i++) send(1'b0, 8'(4 * (40 + i) + (i % 4)), 16'h0, 1'b1, sp);
        idle(80);
        chk(out_max == 4, "R10 peak outstanding", 64'(out_max), 4);
        chk(rsp_n == 6, "R10 rsp count", 64'(rsp_n), 6);
        for (int i = 0; i < 6; i++)
            chk(rsp[i] == shadow[4 * (40 + i) + (i % 4)], "R10 rsp order",
                64'(rsp[i]), 64'(shadow[4 * (40 + i) + (i % 4)]));

        // R9: every stalled wide command was seen unchanged on the next cycle.
        chk(hold_bad == 0, "R9 hold stable", 64'(hold_bad), 0);
        chk(hold_seen > 0, "R9 stalls seen", 64'(hold_seen), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule